// File: doc/BRIEF.md
# Two-Wire Bus Slave with Write Gating

This block is the bidirectional-mode front end of a small byte memory on a two-wire serial bus. It watches the already synchronized clock and data lines and finds START and STOP conditions. It accepts a fixed 7-bit device code followed by a direction bit, and acknowledges each byte it accepts by pulling the data line low.

A write carries a word address and then any number of data bytes. These go to consecutive locations, and the location pointer wraps from the last word back to zero. A read streams bytes out from the pointer for as long as the master acknowledges them.

An external write-enable pin decides, byte by byte, whether a received data byte reaches the memory. A refused byte is still acknowledged, and the pointer still advances past it. A separate mode-enable input holds the whole block silent while the part runs in another mode.

The memory itself sits outside the block. Its read data is expected combinationally from the address the block presents. A write is one clock-wide strobe, issued with its address and data.

Top module: `tw_gated_slave`

## Requirements
- R1: A START, meaning the data line falls while the clock line is high, restarts device-code reception from any state, including in the middle of a byte. The data line is released in the cycle after it.
- R2: The first byte after a START is matched against the device code. With the default parameters the upper seven bits must equal 1010000 (0x50). The lowest bit selects the direction: 0 for write, 1 for read.
- R3: On a match, `sda_oe` is 1 throughout the ninth clock period of the device byte. The same holds for the ninth period of every byte received in a write.
- R4: On a mismatch, the block does not acknowledge. It keeps `sda_oe` at 0 for every following bit until the next START.
- R5: In a write, the second byte loads the word pointer from its low seven bits. Each later byte is written at the pointer, and the pointer then advances, wrapping from 127 to 0.
- R6: `mem_we` pulses for exactly one cycle for each received data byte, but only when `wr_en_i` is 1 at the end of that byte. When `wr_en_i` is 0 the byte is still acknowledged, the pointer still advances, and the memory keeps its old contents.
- R7: In a read, bytes are sent most significant bit first from the pointer, and the pointer advances after each byte. A read right after reset starts at location 0.
- R8: If the master does not acknowledge a read byte, the block releases the data line and stays released until a STOP or a START.
- R9: A STOP, meaning the data line rises while the clock line is high, returns the block to idle. Bytes clocked afterwards without a START receive no acknowledge.
- R10: While `mode_en` is 0, the block neither drives the data line nor issues writes.
- R11: After reset, `sda_oe` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line, as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| mode_en | input | 1 | 1 when the part is in bidirectional mode |
| wr_en_i | input | 1 | Write gate: 1 lets received data reach memory |
| mem_addr | output | ADDR_W | Memory word address (the pointer) |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_rdata | input | 8 | Memory read data for `mem_addr` |

## Verification
The hardest situation to reach is a gated write that is still acknowledged and still advances the pointer. From the ports it looks exactly like a normal write, so the only way to see it is to read the affected words back. The bench toggles `wr_en_i` byte by byte inside one burst. It then performs a random read across the same span and compares each byte against a shadow copy in which only the enabled bytes changed.

A START in the middle of a byte and a read after the master's not-acknowledge are also reached on purpose. The bench truncates a byte after three bits, and it keeps clocking after the not-acknowledge while it counts any cycle in which the block drives the line. The device-code compare is swept over all 128 codes.

// File: rtl/tws_pkg.sv
package tws_pkg;

   localparam int unsigned BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADR,
      ST_ADR_ACK,
      ST_WR,
      ST_WR_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_HOLD
   } tws_state_t;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
   } tws_ev_t;

endpackage

// File: rtl/tws_bus_edges.sv
module tws_bus_edges (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output tws_pkg::tws_ev_t ev
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   always_comb begin
      ev.rise  = scl_i & ~scl_q;
      ev.fall  = ~scl_i & scl_q;
      ev.start = scl_i & scl_q & sda_q & ~sda_i;
      ev.stop  = scl_i & scl_q & ~sda_q & sda_i;
   end

   AST_EV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev.start, ev.stop, ev.rise, ev.fall})); // R1
endmodule

// File: rtl/tws_word_ptr.sv
module tws_word_ptr #(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned DEPTH  = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
   logic [ADDR_W-1:0] nxt;

   generate
      if (DEPTH == (1 << ADDR_W)) begin : g_natural_wrap
         assign nxt = ptr + 1'b1;
      end else begin : g_compare_wrap
         assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr <= '0;
      else if (load) ptr <= load_val;
      else if (step) ptr <= nxt;
   end

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && ptr == LAST) |=> (ptr == '0)); // R5
   AST_PTR_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(step && load)); // R5
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl #(
   parameter int unsigned ADDR_W         = 7,
   parameter logic [6:0]  DEV_CODE       = 7'h50,
   parameter bit          ACK_ON_INHIBIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tws_pkg::tws_ev_t ev,
   input  logic             sda_i,
   input  logic             mode_en,
   input  logic             wr_en_i,
   input  logic [7:0]       mem_rdata,
   output logic             sda_oe,
   output logic             mem_we,
   output logic [7:0]       mem_wdata,
   output logic             ptr_load,
   output logic [ADDR_W-1:0] ptr_val,
   output logic             ptr_step
);
   import tws_pkg::*;

   localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
   localparam logic [3:0] FULL     = 4'(BYTE_W);

   tws_state_t st;
   logic [3:0] cnt;
   logic [7:0] shr;
   logic [7:0] tx;
   logic       rw;
   logic       mack;
   logic       we_q;
   logic       ack_data;

   generate
      if (ACK_ON_INHIBIT) begin : g_ack_always
         assign ack_data = 1'b1;
      end else begin : g_ack_gated
         assign ack_data = wr_en_i;
      end
   endgenerate

   wire byte_done = ev.fall && (cnt == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         shr  <= '0;
         tx   <= '0;
         rw   <= 1'b0;
         mack <= 1'b0;
         we_q <= 1'b0;
      end else begin
         we_q <= 1'b0;
         if (!mode_en) begin
            st <= ST_IDLE;
         end else if (ev.stop) begin
            st <= ST_IDLE;
         end else if (ev.start) begin
            st  <= ST_DEV;
            cnt <= '0;
         end else begin
            case (st)
               ST_DEV, ST_ADR, ST_WR: begin
                  if (ev.rise) begin
                     shr <= {shr[6:0], sda_i};
                     cnt <= cnt + 1'b1;
                  end else if (byte_done) begin
                     cnt <= '0;
                     if (st == ST_DEV) begin
                        if (shr[7:1] == DEV_CODE) begin
                           st <= ST_DEV_ACK;
                           rw <= shr[0];
                        end else begin
                           st <= ST_HOLD;
                        end
                     end else if (st == ST_ADR) begin
                        st <= ST_ADR_ACK;
                     end else begin
                        st   <= ack_data ? ST_WR_ACK : ST_HOLD;
                        we_q <= wr_en_i;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (ev.fall) begin
                     cnt <= '0;
                     if (rw) begin
                        st <= ST_RD;
                        tx <= mem_rdata;
                     end else begin
                        st <= ST_ADR;
                     end
                  end
               end
               ST_ADR_ACK, ST_WR_ACK: begin
                  if (ev.fall) st <= ST_WR;
               end
               ST_RD: begin
                  if (ev.fall) begin
                     if (cnt == LAST_BIT) begin
                        st  <= ST_RD_ACK;
                        cnt <= '0;
                     end else begin
                        tx  <= {tx[6:0], 1'b1};
                        cnt <= cnt + 1'b1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (ev.rise) begin
                     mack <= ~sda_i;
                  end else if (ev.fall) begin
                     if (mack) begin
                        st <= ST_RD;
                        tx <= mem_rdata;
                     end else begin
                        st <= ST_HOLD;
                     end
                  end
               end
               default: st <= st;
            endcase
         end
      end
   end

   always_comb begin
      sda_oe    = (st == ST_DEV_ACK) || (st == ST_ADR_ACK) || (st == ST_WR_ACK)
                  || ((st == ST_RD) && !tx[7]);
      mem_we    = we_q;
      mem_wdata = shr;
      ptr_load  = mode_en && !ev.start && !ev.stop && (st == ST_ADR) && byte_done;
      ptr_val   = shr[ADDR_W-1:0];
      ptr_step  = mode_en && !ev.start && !ev.stop &&
                  (((st == ST_WR_ACK) && ev.fall) ||
                   ((st == ST_RD) && ev.fall && (cnt == LAST_BIT)));
   end

   AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.start && mode_en) |=> !sda_oe); // R1
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ev.stop |=> !sda_oe); // R9
   AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_en |=> (!sda_oe && !mem_we)); // R10
   AST_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> $past(wr_en_i)); // R6
   AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we); // R6
   AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> $stable(mem_wdata)); // R5
endmodule

// File: rtl/tw_gated_slave.sv
module tw_gated_slave #(
   parameter int unsigned ADDR_W         = 7,
   parameter int unsigned DEPTH          = 128,
   parameter logic [6:0]  DEV_CODE       = 7'h50,
   parameter bit          ACK_ON_INHIBIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              mode_en,
   input  logic              wr_en_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              mem_we,
   input  logic [7:0]        mem_rdata
);
   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_addr_w
         $error("tw_gated_slave: ADDR_W must lie in 1..8");
      end
      if (DEPTH < 2 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
         $error("tw_gated_slave: DEPTH must lie in 2..2**ADDR_W");
      end
   endgenerate

   tws_pkg::tws_ev_t  ev;
   logic              ptr_load;
   logic              ptr_step;
   logic [ADDR_W-1:0] ptr_val;

   tws_bus_edges u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .scl_i (scl_i),
      .sda_i (sda_i),
      .ev    (ev)
   );

   tws_ctrl #(
      .ADDR_W         (ADDR_W),
      .DEV_CODE       (DEV_CODE),
      .ACK_ON_INHIBIT (ACK_ON_INHIBIT)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (ev),
      .sda_i     (sda_i),
      .mode_en   (mode_en),
      .wr_en_i   (wr_en_i),
      .mem_rdata (mem_rdata),
      .sda_oe    (sda_oe),
      .mem_we    (mem_we),
      .mem_wdata (mem_wdata),
      .ptr_load  (ptr_load),
      .ptr_val   (ptr_val),
      .ptr_step  (ptr_step)
   );

   tws_word_ptr #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (ptr_val),
      .step     (ptr_step),
      .ptr      (mem_addr)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      $rose(rst_n) |-> (!sda_oe && !mem_we)); // R11
endmodule

// File: tb/tw_gated_slave_bench.sv
module tw_gated_slave_bench;
   localparam int H = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic       mode_en = 1'b1;
   logic       wr_en = 1'b1;
   logic       sda_oe;
   logic [6:0] mem_addr;
   logic [7:0] mem_wdata;
   logic       mem_we;
   logic [7:0] mem_rdata;
   logic       sda_line;

   logic [7:0] mem [128];
   logic [7:0] exp_mem [128];
   int checks = 0;
   int errors = 0;
   int we_cnt = 0;
   int oe_cnt = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign mem_rdata = mem[mem_addr];

   tw_gated_slave u_tw_gated_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .mode_en   (mode_en),
      .wr_en_i   (wr_en),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_we    (mem_we),
      .mem_rdata (mem_rdata)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_we) begin
         mem[mem_addr] <= mem_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (sda_oe) oe_cnt <= oe_cnt + 1;
      if (cyc > 190000) begin
         checks = checks + 1;
         errors = errors + 1;
         $display("FAIL watchdog act=%0d exp=<190000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_out(input logic b);
      scl = 1'b0; w(H); sda_m = b; w(H); scl = 1'b1; w(2*H);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      scl = 1'b0; w(H); sda_m = 1'b1; w(H); scl = 1'b1; w(H);
      ack = sda_oe; w(H);
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         scl = 1'b0; w(H); sda_m = 1'b1; w(H); scl = 1'b1; w(H);
         d[i] = ~sda_oe; w(H);
      end
      scl = 1'b0; w(H); sda_m = ~give_ack; w(H); scl = 1'b1; w(2*H);
   endtask

   task automatic do_start();
      scl = 1'b0; w(H); sda_m = 1'b1; w(H); scl = 1'b1; w(H); sda_m = 1'b0; w(H);
   endtask

   task automatic do_stop();
      scl = 1'b0; w(H); sda_m = 1'b0; w(H); scl = 1'b1; w(H); sda_m = 1'b1; w(H);
   endtask

   task automatic set_ptr(input logic [7:0] a, input string req);
      logic ack;
      do_start();
      send_byte(8'hA0, ack); chk({req, " select ack"}, ack, 1);
      send_byte(a, ack);     chk({req, " address ack"}, ack, 1);
   endtask

   task automatic read_run(input logic [7:0] a, input int n, input string req);
      logic ack;
      logic [7:0] d;
      set_ptr(a, req);
      do_start();
      send_byte(8'hA1, ack); chk({req, " read select ack"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, d);
         chk({req, " read data"}, d, exp_mem[(a + i) % 128]);
      end
      do_stop();
   endtask

   initial begin
      logic ack;
      logic [7:0] d;
      int base;
      for (int i = 0; i < 128; i++) begin
         mem[i]     = 8'(i) ^ 8'h5A;
         exp_mem[i] = 8'(i) ^ 8'h5A;
      end
      w(4);
      chk("R11 sda_oe in reset", sda_oe, 0);
      chk("R11 mem_we in reset", mem_we, 0);
      rst_n = 1'b1;
      w(4);
      chk("R11 sda_oe after reset", sda_oe, 0);

      // R7 current-address read after reset starts at 0
      do_start();
      send_byte(8'hA1, ack); chk("R3 read select ack", ack, 1);
      recv_byte(1'b1, d);    chk("R7 first byte after reset", d, exp_mem[0]);
      recv_byte(1'b0, d);    chk("R7 second byte after reset", d, exp_mem[1]);
      do_stop();

      // R5 full sweep write of all 128 words
      set_ptr(8'h00, "R5");
      for (int i = 0; i < 128; i++) begin
         send_byte(8'((i * 37 + 11) & 255), ack);
         chk("R3 write data ack", ack, 1);
         exp_mem[i] = 8'((i * 37 + 11) & 255);
      end
      do_stop();
      chk("R6 strobe count sweep", we_cnt, 128);
      read_run(8'h00, 128, "R7");

      // R5 wrap from 127 to 0
      set_ptr(8'h7E, "R5 wrap");
      for (int i = 0; i < 3; i++) begin
         send_byte(8'hC0 + 8'(i), ack);
         exp_mem[(126 + i) % 128] = 8'hC0 + 8'(i);
      end
      do_stop();
      read_run(8'h7E, 3, "R5 wrap");

      // R6 writes inhibited
      wr_en = 1'b0;
      base = we_cnt;
      set_ptr(8'h0A, "R6");
      for (int i = 0; i < 3; i++) begin
         send_byte(8'h11 * 8'(i + 1), ack);
         chk("R6 inhibited byte acked", ack, 1);
      end
      do_stop();
      chk("R6 no strobe when inhibited", we_cnt - base, 0);
      wr_en = 1'b1;
      read_run(8'h0A, 3, "R6 memory unchanged");

      // R6 per-byte gating, pointer advances over refused bytes
      set_ptr(8'h28, "R6 mix");
      for (int i = 0; i < 4; i++) begin
         wr_en = (i % 2 == 0);
         send_byte(8'hE0 + 8'(i), ack);
         chk("R6 mixed ack", ack, 1);
         if (i % 2 == 0) exp_mem[40 + i] = 8'hE0 + 8'(i);
      end
      wr_en = 1'b1;
      do_stop();
      read_run(8'h28, 4, "R6 mixed gating");

      // R1 START in the middle of a byte
      set_ptr(8'h20, "R1");
      bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
      do_start();
      send_byte(8'hA1, ack); chk("R1 restart select ack", ack, 1);
      recv_byte(1'b0, d);    chk("R1 read after restart", d, exp_mem[32]);
      do_stop();

      // R2 / R4 sweep over every device code, write direction
      for (int v = 0; v < 128; v++) begin
         do_start();
         send_byte({7'(v), 1'b0}, ack);
         chk("R2 code match", ack, (v == 'h50) ? 1 : 0);
         do_stop();
      end

      // R4 no response after mismatch until next START
      base = oe_cnt;
      do_start();
      send_byte(8'hA2, ack); chk("R4 mismatch no ack", ack, 0);
      send_byte(8'hA0, ack); chk("R4 stays released", ack, 0);
      chk("R4 line never driven", oe_cnt - base, 0);
      do_start();
      send_byte(8'hA0, ack); chk("R4 recovers on START", ack, 1);
      do_stop();

      // R8 master NACK releases the bus
      set_ptr(8'h05, "R8");
      do_start();
      send_byte(8'hA1, ack);
      recv_byte(1'b1, d); chk("R8 byte before nack", d, exp_mem[5]);
      recv_byte(1'b0, d); chk("R8 nacked byte", d, exp_mem[6]);
      base = oe_cnt;
      recv_byte(1'b1, d);
      chk("R8 released after nack", oe_cnt - base, 0);
      chk("R8 idle line reads ones", d, 8'hFF);
      do_stop();

      // R9 bytes after STOP get no acknowledge
      send_byte(8'hA0, ack); chk("R9 no ack without START", ack, 0);
      do_stop();

      // R10 mode disabled
      mode_en = 1'b0;
      base = we_cnt;
      do_start();
      send_byte(8'hA0, ack); chk("R10 no ack when disabled", ack, 0);
      send_byte(8'h30, ack);
      send_byte(8'h99, ack); chk("R10 data not acked", ack, 0);
      do_stop();
      chk("R10 no strobe when disabled", we_cnt - base, 0);
      mode_en = 1'b1;
      w(4);
      read_run(8'h30, 1, "R10 memory unchanged");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule